// File: doc/BRIEF.md
# Outlier Replica Vote Corrector

This block sits between a flash page read path and a matrix-vector arithmetic unit. For each page it protects only the few largest-magnitude weights. A side record supplies, for each such weight, a location index guarded by a single-error-correcting, double-error-detecting code and two spare copies of the value. The block first takes that record, repairs or rejects each location, and fills a small lookup table. It then passes the page values through in order. A value whose index is in the table is replaced by the bitwise two-of-three majority of the value read from the page and its two copies.

Usage runs in two alternating phases. In the first, `N_ENT` spare entries arrive on a valid/ready port. In the second, `PAGE_LEN` page values arrive on a second valid/ready port and leave on a third, one register stage later. While the entries are loading, the page input is held off with `pg_in_ready` low. While the page is streaming, the entry port is held off. Any stage that sees its ready low must keep its valid and data steady. A stall on `out_ready` flows back to `pg_in_ready` in the same cycle. Three counters and a duplicate flag give per-page statistics. They stay readable after a page ends and clear when the first entry of the next page is accepted.

Top module: `opc_page_corrector`

## Requirements
- R1: After reset `ent_ready` is 1, `pg_in_ready` is 0, `out_valid` is 0, all three counters are 0 and `dup_seen` is 0.
- R2: `pg_in_ready` stays 0 until `N_ENT` (default 5, a page of 512 holding 1% outliers) entries have been accepted. `ent_ready` stays 0 while the page streams. The two readies are never both high.
- R3: A page value whose index (its position in the stream, counted from 0) is not in the table appears unchanged on `out_data`. It appears one cycle after it is accepted, and page order is kept.
- R4: For a page value whose index matches a table entry, the output is the bitwise 2-of-3 majority of the page value and the entry's two copies. An entry is `ent_data` = {code[13:0], copy_a[7:0], copy_b[7:0]}, with the code in bits 29:16.
- R5: The 14-bit code places the 9-bit index in Hamming positions 3,5,6,7,9..13 (code bit p-1 is position p, LSB first). Check bits sit at positions 1,2,4,8, and bit 13 is an even parity bit over all 14 bits. A single flipped bit anywhere is corrected, and each such entry adds 1 to `cnt_addr_fix`.
- R6: An entry whose code shows a double error is dropped and adds 1 to `cnt_addr_bad`. The page value at that index then passes unchanged.
- R7: If a second valid entry decodes to an index already held by an earlier entry of the same page, the earlier one is used, the later one is dropped, and `dup_seen` is set.
- R8: `cnt_vote_fix` counts outlier values whose voted result differs from the value read from the page.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady and no value is lost.
- R10: After `PAGE_LEN` values have been accepted, the block returns to loading. The counters keep their page totals until the next page's first entry is accepted, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | Spare entry offered |
| ent_ready | output | 1 | Spare entry can be taken |
| ent_data | input | 30 | {code, copy_a, copy_b} |
| pg_in_valid | input | 1 | Page value offered |
| pg_in_ready | output | 1 | Page value can be taken |
| pg_in_data | input | 8 | Page value |
| out_valid | output | 1 | Corrected value available |
| out_ready | input | 1 | Downstream takes value |
| out_data | output | 8 | Corrected value |
| cnt_addr_fix | output | 3 | Entries with a repaired index this page |
| cnt_addr_bad | output | 3 | Entries dropped as uncorrectable this page |
| cnt_vote_fix | output | 3 | Votes that changed the page value this page |
| dup_seen | output | 1 | A repeated index was dropped this page |

## Verification
The properties assume that each producer keeps valid and data steady until its handshake completes. They also assume that entries arrive only on the entry port and page values only on the page port, each in its own phase. The bench drives both ports to that rule: it stalls at random but never withdraws or changes an offer. The vote can recover the stored value only when, in each bit, at most one of the three replicas is wrong. Random pages therefore corrupt exactly one replica per outlier. Index codes carry at most two flipped bits, which keeps every error inside what the code can detect.

// File: rtl/opc_pkg.sv
package opc_pkg;

  typedef enum logic {
    PH_LOAD,
    PH_STREAM
  } opc_phase_e;

  typedef enum logic [1:0] {
    DEC_CLEAN,
    DEC_FIXED,
    DEC_BAD
  } opc_dec_e;

  // Smallest number of check bits that covers k data bits.
  function automatic int hamm_parity_bits(input int k);
    int p;
    p = 1;
    while ((1 << p) < (k + p + 1)) p++;
    return p;
  endfunction

endpackage

// File: rtl/opc_secded_dec.sv
module opc_secded_dec
  import opc_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PB     = hamm_parity_bits(ADDR_W),
  parameter int HW     = ADDR_W + PB,
  parameter int CODE_W = HW + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] addr_o,
  output opc_dec_e          status_o
);

  logic [PB-1:0]     syn;
  logic              par;
  logic [CODE_W-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int pos = 1; pos <= HW; pos++) begin
      if (code_i[pos-1]) syn ^= PB'(pos);
    end
    par      = ^code_i;
    fixed    = code_i;
    status_o = DEC_CLEAN;
    if (par) begin
      status_o = DEC_FIXED;
      if (syn == '0) begin
        fixed[HW] = ~fixed[HW];
      end else if (int'(syn) <= HW) begin
        fixed[int'(syn)-1] = ~fixed[int'(syn)-1];
      end else begin
        status_o = DEC_BAD;
      end
    end else if (syn != '0) begin
      status_o = DEC_BAD;
    end
  end

  always_comb begin
    int k;
    k      = 0;
    addr_o = '0;
    for (int pos = 1; pos <= HW; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (k < ADDR_W) addr_o[k] = fixed[pos-1];
        k++;
      end
    end
  end

endmodule

// File: rtl/opc_entry_table.sv
module opc_entry_table #(
  parameter int N_ENT  = 5,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int SLOT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_keep,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_a,
  input  logic [DATA_W-1:0] wr_b,
  output logic              dup_o,
  input  logic [ADDR_W-1:0] lk_idx,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_a_o,
  output logic [DATA_W-1:0] hit_b_o
);

  logic [N_ENT-1:0]  dup_vec;
  logic [N_ENT-1:0]  hit_vec;
  logic [DATA_W-1:0] sel_a [N_ENT];
  logic [DATA_W-1:0] sel_b [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    logic              vld_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic              wr_here;

    assign wr_here = wr_en && (wr_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        adr_q <= '0;
        a_q   <= '0;
        b_q   <= '0;
      end else if (wr_here) begin
        vld_q <= wr_keep && !dup_o;
        adr_q <= wr_addr;
        a_q   <= wr_a;
        b_q   <= wr_b;
      end
    end

    // Only slots already written in this page take part in the duplicate test.
    assign dup_vec[g] = vld_q && (SLOT_W'(g) < wr_slot) && (adr_q == wr_addr);
    assign hit_vec[g] = vld_q && (adr_q == lk_idx);
    assign sel_a[g]   = hit_vec[g] ? a_q : '0;
    assign sel_b[g]   = hit_vec[g] ? b_q : '0;
  end

  assign dup_o = |dup_vec;
  assign hit_o = |hit_vec;

  always_comb begin
    hit_a_o = '0;
    hit_b_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      hit_a_o |= sel_a[i];
      hit_b_o |= sel_b[i];
    end
  end

endmodule

// File: rtl/opc_vote_stage.sv
module opc_vote_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              hit,
  input  logic [DATA_W-1:0] cpy_a,
  input  logic [DATA_W-1:0] cpy_b,
  output logic              flip_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] maj;
  logic [DATA_W-1:0] nxt;

  assign maj      = (in_data & cpy_a) | (in_data & cpy_b) | (cpy_a & cpy_b);
  assign nxt      = hit ? maj : in_data;
  assign flip_o   = hit && (maj != in_data);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end

endmodule

// File: rtl/opc_page_corrector.sv
module opc_page_corrector
  import opc_pkg::*;
#(
  parameter int PAGE_LEN = 512,
  parameter int DATA_W   = 8,
  parameter int N_ENT    = PAGE_LEN / 100,
  parameter int ADDR_W   = $clog2(PAGE_LEN),
  parameter int CODE_W   = ADDR_W + hamm_parity_bits(ADDR_W) + 1,
  parameter int ENT_W    = CODE_W + 2 * DATA_W,
  parameter int CNT_W    = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_valid,
  output logic              ent_ready,
  input  logic [ENT_W-1:0]  ent_data,
  input  logic              pg_in_valid,
  output logic              pg_in_ready,
  input  logic [DATA_W-1:0] pg_in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  cnt_addr_fix,
  output logic [CNT_W-1:0]  cnt_addr_bad,
  output logic [CNT_W-1:0]  cnt_vote_fix,
  output logic              dup_seen
);

  localparam int SLOT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int IDX_W  = (PAGE_LEN > 1) ? $clog2(PAGE_LEN) : 1;

  opc_phase_e        phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  idx_q;

  logic [CODE_W-1:0] ent_code;
  logic [DATA_W-1:0] ent_a;
  logic [DATA_W-1:0] ent_b;
  logic [ADDR_W-1:0] dec_addr;
  opc_dec_e          dec_st;
  logic              tbl_dup;
  logic              ent_fire;
  logic              ent_first;
  logic              pg_fire;
  logic              stage_ready;
  logic              hit;
  logic [DATA_W-1:0] hit_a;
  logic [DATA_W-1:0] hit_b;
  logic              flip;

  assign {ent_code, ent_a, ent_b} = ent_data;

  assign ent_ready   = (phase_q == PH_LOAD);
  assign pg_in_ready = (phase_q == PH_STREAM) && stage_ready;
  assign ent_fire    = ent_valid && ent_ready;
  assign ent_first   = ent_fire && (slot_q == '0);
  assign pg_fire     = pg_in_valid && pg_in_ready;

  opc_secded_dec #(.ADDR_W(ADDR_W)) u_dec (
    .code_i  (ent_code),
    .addr_o  (dec_addr),
    .status_o(dec_st)
  );

  opc_entry_table #(
    .N_ENT (N_ENT),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SLOT_W(SLOT_W)
  ) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ent_fire),
    .wr_slot(slot_q),
    .wr_keep(dec_st != DEC_BAD),
    .wr_addr(dec_addr),
    .wr_a   (ent_a),
    .wr_b   (ent_b),
    .dup_o  (tbl_dup),
    .lk_idx (ADDR_W'(idx_q)),
    .hit_o  (hit),
    .hit_a_o(hit_a),
    .hit_b_o(hit_b)
  );

  opc_vote_stage #(.DATA_W(DATA_W)) u_vote (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (pg_in_valid && (phase_q == PH_STREAM)),
    .in_ready (stage_ready),
    .in_data  (pg_in_data),
    .hit      (hit),
    .cpy_a    (hit_a),
    .cpy_b    (hit_b),
    .flip_o   (flip),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  // Phase sequencing: N_ENT entries, then PAGE_LEN values.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      slot_q  <= '0;
      idx_q   <= '0;
    end else if (ent_fire) begin
      if (slot_q == SLOT_W'(N_ENT - 1)) begin
        slot_q  <= '0;
        phase_q <= PH_STREAM;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end else if (pg_fire) begin
      if (idx_q == IDX_W'(PAGE_LEN - 1)) begin
        idx_q   <= '0;
        phase_q <= PH_LOAD;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // Per-page statistics, cleared by the first entry of a page.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_addr_fix <= '0;
      cnt_addr_bad <= '0;
      cnt_vote_fix <= '0;
      dup_seen     <= 1'b0;
    end else if (ent_fire) begin
      cnt_addr_fix <= (ent_first ? '0 : cnt_addr_fix) + CNT_W'(dec_st == DEC_FIXED);
      cnt_addr_bad <= (ent_first ? '0 : cnt_addr_bad) + CNT_W'(dec_st == DEC_BAD);
      dup_seen     <= (ent_first ? 1'b0 : dup_seen) | ((dec_st != DEC_BAD) && tbl_dup);
      if (ent_first) cnt_vote_fix <= '0;
    end else if (pg_fire && flip) begin
      cnt_vote_fix <= cnt_vote_fix + 1'b1;
    end
  end

endmodule

// File: rtl/opc_checker.sv
module opc_checker #(
  parameter int DATA_W = 8,
  parameter int N_ENT  = 5,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ent_valid,
  input logic              ent_ready,
  input logic              pg_in_valid,
  input logic              pg_in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  cnt_addr_fix,
  input logic [CNT_W-1:0]  cnt_addr_bad,
  input logic [CNT_W-1:0]  cnt_vote_fix,
  input logic              dup_seen
);

  assert_excl_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ent_ready && pg_in_ready));

  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_in_valid && pg_in_ready) |=> out_valid);

  assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_addr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_addr_fix) + 32'(cnt_addr_bad)) <= N_ENT);

  assert_dup_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_seen && !(ent_valid && ent_ready)) |=> dup_seen);

  assert_vote_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(pg_in_valid && pg_in_ready) && !(ent_valid && ent_ready)) |=> $stable(cnt_vote_fix));

endmodule

bind opc_page_corrector opc_checker #(
  .DATA_W(DATA_W),
  .N_ENT (N_ENT),
  .CNT_W (CNT_W)
) u_opc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ent_valid   (ent_valid),
  .ent_ready   (ent_ready),
  .pg_in_valid (pg_in_valid),
  .pg_in_ready (pg_in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .cnt_addr_fix(cnt_addr_fix),
  .cnt_addr_bad(cnt_addr_bad),
  .cnt_vote_fix(cnt_vote_fix),
  .dup_seen    (dup_seen)
);

// File: tb/test_opc_page_corrector.sv
module test_opc_page_corrector;

  localparam int PL = 512;
  localparam int NE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ent_valid = 1'b0;
  logic        ent_ready;
  logic [29:0] ent_data = '0;
  logic        pg_in_valid = 1'b0;
  logic        pg_in_ready;
  logic [7:0]  pg_in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic [2:0]  cnt_addr_fix;
  logic [2:0]  cnt_addr_bad;
  logic [2:0]  cnt_vote_fix;
  logic        dup_seen;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  opc_page_corrector i_opc_page_corrector (
    .clk(clk), .rst_n(rst_n),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_data(ent_data),
    .pg_in_valid(pg_in_valid), .pg_in_ready(pg_in_ready), .pg_in_data(pg_in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cnt_addr_fix(cnt_addr_fix), .cnt_addr_bad(cnt_addr_bad),
    .cnt_vote_fix(cnt_vote_fix), .dup_seen(dup_seen)
  );

  // Page model
  logic [7:0] pv [PL];
  logic [7:0] xo [PL];
  bit         xout [PL];
  int         e_addr [NE];
  int         e_kind [NE];
  int         e_b1 [NE];
  int         e_b2 [NE];
  logic [7:0] e_true [NE];
  logic [7:0] e_mask [NE];
  int         e_buck [NE];
  bit         e_act [NE];
  int         x_fix, x_bad, x_vote;
  bit         x_dup;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] enc(input logic [8:0] a);
    logic [13:0] c;
    int k;
    c = '0;
    k = 0;
    for (int pos = 1; pos <= 13; pos++)
      if ((pos & (pos - 1)) != 0) begin c[pos-1] = a[k]; k++; end
    for (int p = 0; p < 4; p++) begin
      logic s;
      s = 1'b0;
      for (int pos = 1; pos <= 13; pos++)
        if (((pos >> p) & 1) == 1 && ((pos & (pos - 1)) != 0)) s ^= c[pos-1];
      c[(1 << p) - 1] = s;
    end
    c[13] = ^c[12:0];
    return c;
  endfunction

  function automatic logic [29:0] entry_word(input int e);
    logic [13:0] c;
    logic [7:0]  ca, cb;
    c = enc(9'(e_addr[e]));
    if (e_kind[e] >= 1) c[e_b1[e]] = ~c[e_b1[e]];
    if (e_kind[e] == 2) c[e_b2[e]] = ~c[e_b2[e]];
    ca = e_true[e] ^ ((e_buck[e] == 1) ? e_mask[e] : 8'h00);
    cb = e_true[e] ^ ((e_buck[e] == 2) ? e_mask[e] : 8'h00);
    return {c, ca, cb};
  endfunction

  // kind: 0 clean edge indices, 1 single index errors, 2 double/dup mix, 3 random
  task automatic make_page(input int kind);
    for (int i = 0; i < PL; i++) pv[i] = 8'($urandom);
    for (int e = 0; e < NE; e++) begin
      int r;
      r         = $urandom_range(0, 9);
      e_addr[e] = $urandom_range(0, PL - 1);
      e_kind[e] = (r < 6) ? 0 : ((r < 9) ? 1 : 2);
      e_b1[e]   = $urandom_range(0, 13);
      e_b2[e]   = (e_b1[e] + 1 + $urandom_range(0, 12)) % 14;
      e_true[e] = 8'($urandom);
      e_mask[e] = 8'($urandom);
      e_buck[e] = $urandom_range(0, 2);
    end
    if (kind == 3 && $urandom_range(0, 3) == 0) e_addr[4] = e_addr[1];
    if (kind == 0) begin
      e_addr[0] = 0; e_addr[1] = PL - 1; e_addr[2] = 100; e_addr[3] = 200; e_addr[4] = 300;
      for (int e = 0; e < NE; e++) begin
        e_kind[e] = 0; e_buck[e] = 0; e_mask[e] = 8'($urandom) | 8'h01;
      end
    end
    if (kind == 1) begin
      e_b1[0] = 0; e_b1[1] = 13; e_b1[2] = 2; e_b1[3] = 7; e_b1[4] = 12;
      for (int e = 0; e < NE; e++) begin
        e_kind[e] = 1; e_addr[e] = 10 * (e + 1); e_buck[e] = 0; e_mask[e] = 8'h81;
      end
    end
    if (kind == 2) begin
      e_addr[0] = 77;  e_kind[0] = 0;
      e_addr[1] = 77;  e_kind[1] = 0;
      e_addr[2] = 400; e_kind[2] = 2; e_b1[2] = 3; e_b2[2] = 9;
      e_addr[3] = 401; e_kind[3] = 1; e_b1[3] = 5;
      e_addr[4] = 511; e_kind[4] = 0;
      for (int e = 0; e < NE; e++) begin e_buck[e] = 0; e_mask[e] = 8'h3c; end
      e_true[1] = ~e_true[0];
    end
    x_fix = 0; x_bad = 0; x_vote = 0; x_dup = 0;
    for (int e = 0; e < NE; e++) begin
      e_act[e] = (e_kind[e] != 2);
      if (e_kind[e] == 1) x_fix++;
      if (e_kind[e] == 2) x_bad++;
      if (e_act[e])
        for (int j = 0; j < e; j++)
          if (e_act[j] && e_addr[j] == e_addr[e]) begin e_act[e] = 0; x_dup = 1; end
    end
    for (int e = 0; e < NE; e++)
      if (!e_act[e]) pv[e_addr[e]] = e_true[e] ^ e_mask[e];
    for (int i = 0; i < PL; i++) begin xo[i] = pv[i]; xout[i] = 0; end
    for (int e = 0; e < NE; e++)
      if (e_act[e]) begin
        pv[e_addr[e]]   = e_true[e] ^ ((e_buck[e] == 0) ? e_mask[e] : 8'h00);
        xo[e_addr[e]]   = e_true[e];
        xout[e_addr[e]] = 1;
        if (pv[e_addr[e]] != e_true[e]) x_vote++;
      end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic load_entries(input bit after_first_page);
    for (int e = 0; e < NE; e++) begin
      bit acc;
      ent_valid = 1'b1;
      ent_data  = entry_word(e);
      acc = 0;
      while (!acc) begin
        #1;
        acc = ent_ready;
        if (e == 2) check(pg_in_ready == 1'b0, "R2 page held off during load", pg_in_ready, 0);
        @(negedge clk);
      end
      if (e == 0 && after_first_page)
        check(cnt_vote_fix == 3'd0, "R10 counters cleared by first entry", cnt_vote_fix, 0);
    end
    ent_valid = 1'b0;
  endtask

  task automatic stream_page();
    int  sent, recv;
    bit  in_acc, hold_pend;
    logic [7:0] hold_val;
    sent = 0; recv = 0; in_acc = 0; hold_pend = 0; hold_val = '0;
    while (recv < PL) begin
      if (in_acc) begin pg_in_valid = 1'b0; sent++; in_acc = 0; end
      if (!pg_in_valid && sent < PL && $urandom_range(0, 9) < 8) begin
        pg_in_valid = 1'b1;
        pg_in_data  = pv[sent];
      end
      out_ready = ($urandom_range(0, 9) < 7);
      #1;
      if (hold_pend) begin
        check(out_valid && out_data == hold_val, "R9 output held under stall", out_data, hold_val);
        hold_pend = 0;
      end
      if (sent == 3 && recv < 2) check(ent_ready == 1'b0, "R2 entries held off during stream", ent_ready, 0);
      if (pg_in_valid && pg_in_ready) in_acc = 1;
      if (out_valid && out_ready) begin
        if (xout[recv]) check(out_data == xo[recv], "R4 voted outlier", out_data, xo[recv]);
        else            check(out_data == xo[recv], "R3 pass-through value", out_data, xo[recv]);
        recv++;
      end else if (out_valid) begin
        hold_pend = 1; hold_val = out_data;
      end
      @(negedge clk);
    end
    pg_in_valid = 1'b0;
    out_ready   = 1'b0;
    #1;
    check(cnt_addr_fix == 3'(x_fix), "R5 corrected index count", cnt_addr_fix, x_fix);
    check(cnt_addr_bad == 3'(x_bad), "R6 uncorrectable index count", cnt_addr_bad, x_bad);
    check(cnt_vote_fix == 3'(x_vote), "R8 vote change count", cnt_vote_fix, x_vote);
    check(dup_seen == x_dup, "R7 duplicate flag", dup_seen, x_dup);
    check(ent_ready && !pg_in_ready, "R10 back to loading", ent_ready, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(ent_ready == 1'b1, "R1 ent_ready after reset", ent_ready, 1);
    check(pg_in_ready == 1'b0, "R1 pg_in_ready after reset", pg_in_ready, 0);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(cnt_addr_fix == 0 && cnt_addr_bad == 0 && cnt_vote_fix == 0 && !dup_seen,
          "R1 statistics after reset", cnt_addr_fix, 0);
    @(negedge clk);
    for (int pg = 0; pg < 9; pg++) begin
      make_page((pg < 3) ? pg : 3);
      load_entries(pg != 0);
      stream_page();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule